// File: doc/BRIEF.md
# Tenant-Change Partition Flush Sequencer

This block guards one protected cache partition that is bound to a single core. At every context switch on that core, the scheduler presents the incoming task's tenant domain ID on a request/acknowledge handshake. The block compares that ID with the domain that last ran in the region. When the two match, it acknowledges at once. When they differ, it walks the whole partition first. The walk issues one line-sized memory access per cache line across a contiguous buffer the size of the partition, so the previous tenant's lines are displaced. The acknowledge is given only after that walk ends.

The partition's base address and byte size come in as inputs and are captured when the switch request is taken. Memory accesses leave on a valid/ready request port. A busy output marks the walk. The block keeps its own record of the last domain and a flag for whether that record is valid. Reset clears the flag, so the first switch after reset always causes a walk. Other partitions and the cache itself lie outside this block. One instance is placed per protected region.

Top module: `partition_scrub_seq`

## Requirements
- R1: After reset, sw_ack_o, busy_o and mem_req_valid_o are low.
- R2: The first switch request after reset starts a full partition walk, whatever its domain ID.
- R3: On a domain mismatch, the block issues exactly N = part_size_i / LINE_BYTES memory requests (LINE_BYTES = 64, size a multiple of 64). Their addresses are part_base_i + k*64 for k = 0 to N-1, in ascending order, each issued once.
- R4: On a domain match, sw_ack_o goes high on the cycle after the request is taken, and no memory request is issued. sw_ack_o is always a one-cycle pulse.
- R5: The stored last domain changes only when a walk completes. A matching switch leaves it unchanged.
- R6: busy_o is high from the cycle after a mismatching request is taken until the final line request is accepted. On the next cycle busy_o is low and sw_ack_o is high.
- R7: sw_ack_o is never high while busy_o is high, so a switch is held off until its walk ends.
- R8: A memory request that is not accepted keeps mem_req_valid_o high and mem_req_addr_o unchanged until mem_req_ready_i is seen.
- R9: Base and size are captured when the request is taken. Changes to them during a walk have no effect on the addresses or the count.
- R10: A mismatching switch with a size below one line issues no memory request. It is acknowledged on the next cycle and records the new domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_req_i | input | 1 | Context-switch request, held until acknowledged |
| sw_domain_i | input | DOM_W | Incoming task's domain ID |
| part_base_i | input | ADDR_W | Partition base byte address |
| part_size_i | input | ADDR_W | Partition size in bytes |
| sw_ack_o | output | 1 | One-cycle switch acknowledge |
| busy_o | output | 1 | Partition walk in progress |
| mem_req_valid_o | output | 1 | Line access request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Line-aligned access address |

## Verification
The bench first uses domain zero right after reset. A design that trusted its reset-cleared domain register would wrongly treat that switch as a match and skip the walk. It then stalls the memory port on a regular pattern. A walker that advanced without a handshake would skip or repeat line addresses, or drop valid early. It repeats the just-flushed domain and then an older one, which catches a last-domain register updated at the wrong time or never updated. A base and size are changed in the middle of a walk to expose uncaptured inputs. A sub-line size checks that the walker neither wraps its counter into a huge walk nor fails to record the domain.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_ACK  = 2'd2
  } scrub_state_e;
endpackage

// File: rtl/scrub_domain_reg.sv
module scrub_domain_reg #(
  parameter int DOM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [DOM_W-1:0] upd_dom_i,
  input  logic [DOM_W-1:0] cmp_dom_i,
  output logic             match_o
);
  logic             vld_q;
  logic [DOM_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      last_q <= '0;
    end else if (upd_i) begin
      vld_q  <= 1'b1;
      last_q <= upd_dom_i;
    end
  end

  assign match_o = vld_q && (last_q == cmp_dom_i);

  // R5
  last_dom_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(last_q) && $stable(vld_q));
endmodule

// File: rtl/scrub_line_walker.sv
module scrub_line_walker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              empty_o
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam int CNT_W      = ADDR_W - LINE_SHIFT;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  lines_q;
  logic [CNT_W-1:0]  lines_in;

  assign lines_in = size_i[ADDR_W-1:LINE_SHIFT];
  assign empty_o  = (lines_in == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      idx_q   <= '0;
      lines_q <= '0;
    end else if (start_i) begin
      base_q  <= {base_i[ADDR_W-1:LINE_SHIFT], {LINE_SHIFT{1'b0}}};
      idx_q   <= '0;
      lines_q <= lines_in;
    end else if (adv_i && !last_o) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign addr_o = base_q + {idx_q, {LINE_SHIFT{1'b0}}};
  assign last_o = (idx_q == lines_q - 1'b1);

  // R3
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> idx_q < lines_q);
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int DOM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_req_i,
  input  logic [DOM_W-1:0] sw_domain_i,
  input  logic             match_i,
  input  logic             empty_i,
  input  logic             last_i,
  input  logic             mem_ready_i,
  output logic             walk_start_o,
  output logic             walk_adv_o,
  output logic             upd_o,
  output logic [DOM_W-1:0] upd_dom_o,
  output logic             mem_valid_o,
  output logic             busy_o,
  output logic             ack_o
);
  scrub_state_e     state_q, state_d;
  logic [DOM_W-1:0] dom_q;
  logic             take;

  assign take = (state_q == ST_IDLE) && sw_req_i;

  always_comb begin
    state_d = state_q;
    upd_o   = 1'b0;
    case (state_q)
      ST_IDLE: if (sw_req_i) begin
        if (match_i) begin
          state_d = ST_ACK;
        end else if (empty_i) begin
          state_d = ST_ACK;
          upd_o   = 1'b1;
        end else begin
          state_d = ST_WALK;
        end
      end
      ST_WALK: if (mem_ready_i && last_i) begin
        state_d = ST_ACK;
        upd_o   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dom_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take) dom_q <= sw_domain_i;
    end
  end

  assign upd_dom_o    = (state_q == ST_IDLE) ? sw_domain_i : dom_q;
  assign walk_start_o = take && !match_i && !empty_i;
  assign mem_valid_o  = (state_q == ST_WALK);
  assign walk_adv_o   = mem_valid_o && mem_ready_i;
  assign busy_o       = (state_q == ST_WALK);
  assign ack_o        = (state_q == ST_ACK);

  // R7
  ack_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !busy_o);
  // R4
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/partition_scrub_seq.sv
module partition_scrub_seq #(
  parameter int DOM_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_req_i,
  input  logic [DOM_W-1:0]  sw_domain_i,
  input  logic [ADDR_W-1:0] part_base_i,
  input  logic [ADDR_W-1:0] part_size_i,
  output logic              sw_ack_o,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o
);
  logic             match, empty, last, start, adv, upd;
  logic [DOM_W-1:0] upd_dom;

  scrub_domain_reg #(.DOM_W(DOM_W)) u_dom (
    .clk_i, .rst_ni, .upd_i(upd), .upd_dom_i(upd_dom),
    .cmp_dom_i(sw_domain_i), .match_o(match)
  );

  scrub_line_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk_i, .rst_ni, .start_i(start), .base_i(part_base_i),
    .size_i(part_size_i), .adv_i(adv), .addr_o(mem_req_addr_o),
    .last_o(last), .empty_o(empty)
  );

  scrub_ctrl #(.DOM_W(DOM_W)) u_ctrl (
    .clk_i, .rst_ni, .sw_req_i, .sw_domain_i, .match_i(match),
    .empty_i(empty), .last_i(last), .mem_ready_i(mem_req_ready_i),
    .walk_start_o(start), .walk_adv_o(adv), .upd_o(upd),
    .upd_dom_o(upd_dom), .mem_valid_o(mem_req_valid_o),
    .busy_o(busy_o), .ack_o(sw_ack_o)
  );

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  // R6
  valid_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> busy_o);
endmodule

// File: tb/partition_scrub_seq_bench.sv
module partition_scrub_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_req = 1'b0;
  logic [7:0]  sw_dom = '0;
  logic [31:0] base = '0;
  logic [31:0] size = '0;
  logic        ack, busy, mvalid;
  logic        mready = 1'b0;
  logic [31:0] maddr;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  partition_scrub_seq u_partition_scrub_seq (
    .clk_i(clk), .rst_ni(rst_n), .sw_req_i(sw_req), .sw_domain_i(sw_dom),
    .part_base_i(base), .part_size_i(size), .sw_ack_o(ack), .busy_o(busy),
    .mem_req_valid_o(mvalid), .mem_req_ready_i(mready), .mem_req_addr_o(maddr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // stall: 0 = ready always; else ready low when cycle % stall == 0
  task automatic run_switch(input logic [7:0] dom, input logic [31:0] b,
                            input logic [31:0] sz, input bit exp_flush,
                            input int stall, input bit scramble, input string rq);
    int     lines = exp_flush ? int'(sz / 64) : 0;
    int     k = 0;
    int     cyc = 0;
    bit     bad_addr = 1'b0;
    bit     busy_gap = 1'b0;
    bit     prev_last_acc = 1'b0;
    bit     got_ack = 1'b0;
    longint bad_val = 0;
    longint bad_exp = 0;
    @(negedge clk);
    sw_dom = dom; base = b; size = sz; sw_req = 1'b1;
    while (!got_ack && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      mready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (ack) begin
        got_ack = 1'b1;
        chk(busy == 1'b0, "R7", "busy at ack", longint'(busy), 0);
        if (lines > 0)
          chk(prev_last_acc, "R6", "ack right after last accept", longint'(prev_last_acc), 1);
        else
          chk(cyc == 1, "R4", "ack latency", cyc, 1);
        sw_req = 1'b0;
        mready = 1'b0;
      end else begin
        if (lines > 0 && !busy) busy_gap = 1'b1;
        prev_last_acc = 1'b0;
        if (mvalid && mready) begin
          if (maddr != b + 32'(k) * 64 && !bad_addr) begin
            bad_addr = 1'b1; bad_val = maddr; bad_exp = b + 32'(k) * 64;
          end
          k++;
          prev_last_acc = (k == lines);
          if (scramble && k == 1) begin base = 32'hDEAD0000; size = 32'h40; end
        end
      end
    end
    chk(got_ack, rq, "ack seen", longint'(got_ack), 1);
    chk(k == lines, rq, "line requests", k, lines);
    chk(!bad_addr, rq, "line address", bad_val, bad_exp);
    if (lines > 0) chk(!busy_gap, "R6", "busy held during walk", 0, 1);
    @(negedge clk);
    chk(!ack && !mvalid && !busy, "R4", "ack single pulse, idle after",
        longint'({ack, mvalid, busy}), 0);
  endtask

  task automatic t_reset();
    chk(!ack, "R1", "ack after reset", longint'(ack), 0);
    chk(!busy, "R1", "busy after reset", longint'(busy), 0);
    chk(!mvalid, "R1", "valid after reset", longint'(mvalid), 0);
  endtask

  task automatic t_hold();
    // R8: with ready low, valid and address must stay put
    logic [31:0] a0;
    @(negedge clk);
    sw_dom = 8'd42; base = 32'h8000; size = 32'd256; sw_req = 1'b1; mready = 1'b0;
    @(negedge clk);
    a0 = maddr;
    repeat (3) @(negedge clk);
    chk(mvalid && maddr == a0, "R8", "held request address", longint'(maddr), longint'(a0));
    chk(!ack, "R7", "no ack while stalled", longint'(ack), 0);
    mready = 1'b1;
    while (!ack) @(negedge clk);
    sw_req = 1'b0; mready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_switch(8'd0, 32'h0000_1000, 32'd256, 1'b1, 0, 1'b0, "R2");
    run_switch(8'd0, 32'h0000_1000, 32'd256, 1'b0, 0, 1'b0, "R4");
    run_switch(8'd7, 32'h0002_0000, 32'd640, 1'b1, 3, 1'b0, "R3");
    run_switch(8'd7, 32'h0002_0000, 32'd640, 1'b0, 0, 1'b0, "R5");
    run_switch(8'd0, 32'h0004_0000, 32'd512, 1'b1, 2, 1'b1, "R9");
    run_switch(8'd9, 32'h0005_0000, 32'd32,  1'b0, 0, 1'b0, "R10");
    run_switch(8'd9, 32'h0005_0000, 32'd128, 1'b0, 0, 1'b0, "R10");
    run_switch(8'd3, 32'h0006_0000, 32'd64,  1'b1, 0, 1'b0, "R3");
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule